// File: doc/BRIEF.md
# Omega Self-Routing Switching Network

This block is an N-by-N multistage switching network of the omega type. It has log2(N) stages, and each stage holds N/2 two-by-two switch elements. A fixed perfect-shuffle wiring sits in front of every stage. Each input lane carries a valid bit, a destination tag, a broadcast request bit and a data payload. Each output lane presents a valid bit and the delivered payload. There is no central controller: every switch element works out its own setting from the destination tag bits of the packets that reach it.

The network is blocking, so some sets of destinations cannot all be delivered in one pass. When two packets in one switch want the same output, the packet on the upper input goes through and the packet on the lower input is discarded. The discard is reported against the input lane the discarded packet came from.

The first stage can also fan a packet out to both of its outputs. This broadcast is allowed only when the other input of that switch is idle.

Every stage is registered, so a new group of packets (a wave) can enter on every clock. Each wave reaches the outputs log2(N) cycles after it entered. Its discard flags come out in the same cycle as its delivered packets.

Top module: `omega_net`

## Requirements
- R1: A single valid packet sampled at a rising edge appears on `out_valid_o[dest]` and `out_data_o[dest]` after exactly log2(N) rising edges. All output valids are low in the cycles before that.
- R2: When no switch sees two packets that want the same output, every valid packet is delivered with its payload unchanged and `blocked_o` stays all zero. For example, the identity pattern (input i sent to output i) is fully delivered.
- R3: Routing works as follows. A perfect shuffle before each stage moves lane i to lane rotl(i), a left rotation of its log2(N) index bits. Stage k then routes on destination bit log2(N)-1-k, so the most significant bit is used first. A 0 sends the packet to the upper (even) output of its switch and a 1 sends it to the lower (odd) output. A delivered packet therefore appears on the output whose index equals its destination tag.
- R4: When both inputs of a switch want the same output, the packet on the upper (even-lane) input wins. The lower packet is discarded, and `blocked_o[src]` is high for its source lane in the cycle its wave reaches the outputs.
- R5: A packet with `in_bcast_i` set is broadcast if the other input of its first-stage switch is idle; that other input is input lane i XOR N/2. The packet then reaches two outputs: its destination with the top bit cleared and its destination with the top bit set. The broadcast bit has no effect after the first stage. From there the two copies route normally and can be blocked like any other packet.
- R6: A broadcast request whose first-stage partner lane is valid is discarded and reported on `blocked_o`, and the partner routes normally. If both lanes of a first-stage switch request broadcast, both packets are discarded.
- R7: While `rst_ni` is low, `out_valid_o` and `blocked_o` are zero whatever the inputs. After release they stay zero until the first valid wave arrives.
- R8: A new wave is accepted on every cycle. The valid, payload and blocked outputs of a wave depend only on that wave, even when waves enter back to back.
- R9: An input lane with `in_valid_i` low has no effect on any output, whatever its broadcast, destination or data values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Per-lane packet valid |
| in_bcast_i | input | N_PORTS | Per-lane broadcast request, acted on in the first stage only |
| in_dest_i | input | N_PORTS x log2(N_PORTS) | Per-lane destination tag |
| in_data_i | input | N_PORTS x DATA_W | Per-lane payload |
| out_valid_o | output | N_PORTS | Per-output delivery valid |
| out_data_o | output | N_PORTS x DATA_W | Per-output delivered payload |
| blocked_o | output | N_PORTS | Per-source discard flag, aligned with the wave's outputs |

## Verification
Broadcast and conflict arbitration can fall in the same wave. A broadcast first blocks or is blocked by its partner in the first stage. Its two copies can then collide with unrelated packets in a later stage, and there the upper-wins rule decides again. This is provoked by table waves that mix broadcast requests with dense destinations, and by a long back-to-back run of pseudo-random waves with sparse broadcast bits. Each wave's valid lanes, payloads and per-source blocked flags are judged against a stage-by-stage shuffle-exchange model in the bench.

// File: rtl/omega_pkg.sv
package omega_pkg;
  typedef enum logic [1:0] {
    SW_STRAIGHT = 2'd0,
    SW_CROSS    = 2'd1,
    SW_UBC      = 2'd2,
    SW_LBC      = 2'd3
  } sw_mode_e;
endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter bit BCAST_EN = 1'b0
) (
  input  logic     u_valid_i,
  input  logic     u_bcast_i,
  input  logic     u_bit_i,
  input  logic     l_valid_i,
  input  logic     l_bcast_i,
  input  logic     l_bit_i,
  output sw_mode_e mode_o,
  output logic [1:0] out_valid_o,
  output logic     u_drop_o,
  output logic     l_drop_o
);
  logic u_req, l_req, u_grant, l_grant, u_ok, l_ok, bc, src0_l, src1_l;

  assign u_req   = BCAST_EN && u_valid_i && u_bcast_i;
  assign l_req   = BCAST_EN && l_valid_i && l_bcast_i;
  assign u_grant = u_req && !l_valid_i;
  assign l_grant = l_req && !u_valid_i;

  // broadcast needs an idle partner; same-side collision drops the lower packet
  assign u_drop_o = u_req && l_valid_i;
  assign l_drop_o = (l_req && u_valid_i) ||
                    (l_valid_i && !l_req && u_valid_i && !u_req && (u_bit_i == l_bit_i));

  assign u_ok = u_valid_i && !u_drop_o;
  assign l_ok = l_valid_i && !l_drop_o;

  always_comb begin
    if (u_grant)      mode_o = SW_UBC;
    else if (l_grant) mode_o = SW_LBC;
    else if (u_ok)    mode_o = u_bit_i ? SW_CROSS : SW_STRAIGHT;
    else if (l_ok)    mode_o = l_bit_i ? SW_STRAIGHT : SW_CROSS;
    else              mode_o = SW_STRAIGHT;
  end

  assign bc     = (mode_o == SW_UBC) || (mode_o == SW_LBC);
  assign src0_l = (mode_o == SW_CROSS) || (mode_o == SW_LBC);
  assign src1_l = (mode_o == SW_STRAIGHT) || (mode_o == SW_LBC);

  assign out_valid_o[0] = src0_l ? (l_ok && (bc || !l_bit_i)) : (u_ok && (bc || !u_bit_i));
  assign out_valid_o[1] = src1_l ? (l_ok && (bc ||  l_bit_i)) : (u_ok && (bc ||  u_bit_i));
endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned STAGE   = 0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_PORTS-1:0]               valid_i,
  input  logic [N_PORTS-1:0]               bcast_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0]   dest_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0]   src_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0]   data_i,
  input  logic [N_PORTS-1:0]               blk_i,
  output logic [N_PORTS-1:0]               valid_o,
  output logic [N_PORTS-1:0][ADDR_W-1:0]   dest_o,
  output logic [N_PORTS-1:0][ADDR_W-1:0]   src_o,
  output logic [N_PORTS-1:0][DATA_W-1:0]   data_o,
  output logic [N_PORTS-1:0]               blk_o
);
  localparam int unsigned HALF  = N_PORTS / 2;
  localparam int unsigned ROUTE = ADDR_W - 1 - STAGE;

  logic [N_PORTS-1:0]             sh_valid, sh_bcast, nx_valid;
  logic [N_PORTS-1:0][ADDR_W-1:0] sh_dest, sh_src, nx_dest, nx_src;
  logic [N_PORTS-1:0][DATA_W-1:0] sh_data, nx_data;
  logic [N_PORTS-1:0]             blk_nxt;
  logic [HALF-1:0]                u_drop, l_drop;
  sw_mode_e                       sw_mode [HALF];

  // perfect shuffle: rotate lane index left by one
  for (genvar i = 0; i < N_PORTS; i++) begin : g_shuf
    localparam int unsigned P = ((i << 1) | (i >> (ADDR_W - 1))) % N_PORTS;
    assign sh_valid[P] = valid_i[i];
    assign sh_bcast[P] = bcast_i[i];
    assign sh_dest[P]  = dest_i[i];
    assign sh_src[P]   = src_i[i];
    assign sh_data[P]  = data_i[i];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_sw
    logic [1:0] ov;
    logic       sel_l0, sel_l1;

    omega_switch #(.BCAST_EN(STAGE == 0)) u_sw (
      .u_valid_i  (sh_valid[2*j]),
      .u_bcast_i  (sh_bcast[2*j]),
      .u_bit_i    (sh_dest[2*j][ROUTE]),
      .l_valid_i  (sh_valid[2*j+1]),
      .l_bcast_i  (sh_bcast[2*j+1]),
      .l_bit_i    (sh_dest[2*j+1][ROUTE]),
      .mode_o     (sw_mode[j]),
      .out_valid_o(ov),
      .u_drop_o   (u_drop[j]),
      .l_drop_o   (l_drop[j])
    );

    assign sel_l0 = (sw_mode[j] == SW_CROSS) || (sw_mode[j] == SW_LBC);
    assign sel_l1 = (sw_mode[j] == SW_STRAIGHT) || (sw_mode[j] == SW_LBC);

    assign nx_valid[2*j]   = ov[0];
    assign nx_valid[2*j+1] = ov[1];
    assign nx_dest[2*j]    = sel_l0 ? sh_dest[2*j+1] : sh_dest[2*j];
    assign nx_dest[2*j+1]  = sel_l1 ? sh_dest[2*j+1] : sh_dest[2*j];
    assign nx_src[2*j]     = sel_l0 ? sh_src[2*j+1]  : sh_src[2*j];
    assign nx_src[2*j+1]   = sel_l1 ? sh_src[2*j+1]  : sh_src[2*j];
    assign nx_data[2*j]    = sel_l0 ? sh_data[2*j+1] : sh_data[2*j];
    assign nx_data[2*j+1]  = sel_l1 ? sh_data[2*j+1] : sh_data[2*j];

    // R4
    upper_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sh_valid[2*j] && !((STAGE == 0) && sh_bcast[2*j])) |-> !u_drop[j]);

    // R6
    bcast_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((sw_mode[j] == SW_UBC && sh_valid[2*j+1]) ||
        (sw_mode[j] == SW_LBC && sh_valid[2*j]) ||
        ((STAGE != 0) && (sw_mode[j] == SW_UBC || sw_mode[j] == SW_LBC))));
  end

  always_comb begin
    blk_nxt = blk_i;
    for (int j = 0; j < HALF; j++) begin
      if (u_drop[j]) blk_nxt[sh_src[2*j]]   = 1'b1;
      if (l_drop[j]) blk_nxt[sh_src[2*j+1]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      dest_o  <= '0;
      src_o   <= '0;
      data_o  <= '0;
      blk_o   <= '0;
    end else begin
      valid_o <= nx_valid;
      dest_o  <= nx_dest;
      src_o   <= nx_src;
      data_o  <= nx_data;
      blk_o   <= blk_nxt;
    end
  end

  if (STAGE > 0) begin : g_chk
    // R3
    for (genvar p = 0; p < N_PORTS; p++) begin : g_lane
      route_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[p] |-> (dest_o[p][ROUTE] == 1'(p % 2)));
    end

    // R4
    lane_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ($countones(valid_o) ==
                $past($countones(sh_valid) - $countones(u_drop) - $countones(l_drop))));
  end
endmodule

// File: rtl/omega_net.sv
module omega_net
  import omega_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned ADDR_W = $clog2(N_PORTS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             in_valid_i,
  input  logic [N_PORTS-1:0]             in_bcast_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] in_dest_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] in_data_i,
  output logic [N_PORTS-1:0]             out_valid_o,
  output logic [N_PORTS-1:0][DATA_W-1:0] out_data_o,
  output logic [N_PORTS-1:0]             blocked_o
);
  localparam int unsigned N_STAGES = ADDR_W;

  logic [N_PORTS-1:0]             lv [N_STAGES+1];
  logic [N_PORTS-1:0]             lb [N_STAGES+1];
  logic [N_PORTS-1:0][ADDR_W-1:0] ld [N_STAGES+1];
  logic [N_PORTS-1:0][ADDR_W-1:0] ls [N_STAGES+1];
  logic [N_PORTS-1:0][DATA_W-1:0] lx [N_STAGES+1];

  assign lv[0] = in_valid_i;
  assign ld[0] = in_dest_i;
  assign lx[0] = in_data_i;
  assign lb[0] = '0;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_src
    assign ls[0][i] = ADDR_W'(i);
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    omega_stage #(
      .N_PORTS(N_PORTS),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STAGE  (s)
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(lv[s]),
      .bcast_i((s == 0) ? in_bcast_i : '0),
      .dest_i (ld[s]),
      .src_i  (ls[s]),
      .data_i (lx[s]),
      .blk_i  (lb[s]),
      .valid_o(lv[s+1]),
      .dest_o (ld[s+1]),
      .src_o  (ls[s+1]),
      .data_o (lx[s+1]),
      .blk_o  (lb[s+1])
    );
  end

  assign out_valid_o = lv[N_STAGES];
  assign out_data_o  = lx[N_STAGES];
  assign blocked_o   = lb[N_STAGES];

  logic unused_tail;
  assign unused_tail = ^{ld[N_STAGES], ls[N_STAGES]};
endmodule

// File: tb/omega_net_test.sv
`timescale 1ns/1ps
module omega_net_test;
  localparam int N  = 8;
  localparam int A  = 3;
  localparam int DW = 8;

  typedef struct packed {
    logic [7:0]  v;
    logic [7:0]  b;
    logic [23:0] d;
    logic [7:0]  seed;
    logic [3:0]  req_v;
    logic [3:0]  req_b;
  } vec_t;

  // octal dest field: rightmost digit is lane 0
  localparam vec_t VECS [10] = '{
    '{8'hFF, 8'h00, 24'o76543210, 8'h11, 4'd2, 4'd2},
    '{8'hFF, 8'h00, 24'o01234567, 8'h23, 4'd3, 4'd4},
    '{8'hFF, 8'h00, 24'o00000000, 8'h35, 4'd3, 4'd4},
    '{8'hFF, 8'h00, 24'o07654321, 8'h47, 4'd3, 4'd4},
    '{8'h20, 8'h00, 24'o00200000, 8'h59, 4'd3, 4'd4},
    '{8'h02, 8'h02, 24'o00000050, 8'h6B, 4'd5, 4'd5},
    '{8'h22, 8'h02, 24'o00300050, 8'h7D, 4'd6, 4'd6},
    '{8'h09, 8'h09, 24'o00007002, 8'h8F, 4'd5, 4'd5},
    '{8'h00, 8'hFF, 24'o52717364, 8'h91, 4'd9, 4'd9},
    '{8'hA5, 8'h04, 24'o31427560, 8'hA3, 4'd5, 4'd6}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]         in_valid = '0, in_bcast = '0;
  logic [N-1:0][A-1:0]  in_dest = '0;
  logic [N-1:0][DW-1:0] in_data = '0;
  logic [N-1:0]         out_valid, blocked;
  logic [N-1:0][DW-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit [31:0] lfsr = 32'h1ACE_B00C;

  logic [N-1:0]         q_ev [128];
  logic [N-1:0]         q_eb [128];
  logic [N-1:0][DW-1:0] q_ex [128];
  string                q_tv [128];
  string                q_tb [128];

  always #4 clk = ~clk;

  omega_net #(.N_PORTS(N), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_bcast_i(in_bcast), .in_dest_i(in_dest), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .blocked_o(blocked)
  );

  function automatic string tag(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  function automatic bit [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic check(string t, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", t, what, act, exp);
    end
  endtask

  // shuffle-exchange reference, stage by stage
  task automatic model(input logic [N-1:0] v, input logic [N-1:0] b,
                       input logic [N-1:0][A-1:0] d, input logic [N-1:0][DW-1:0] x,
                       output logic [N-1:0] ev, output logic [N-1:0] eb,
                       output logic [N-1:0][DW-1:0] ex);
    bit cv[N]; int cd[N]; int cs[N]; logic [DW-1:0] cx[N]; bit cb[N];
    bit sv[N]; int sd[N]; int ss[N]; logic [DW-1:0] sx[N]; bit sb[N];
    eb = '0;
    for (int i = 0; i < N; i++) begin
      cv[i] = v[i]; cd[i] = int'(d[i]); cs[i] = i; cx[i] = x[i]; cb[i] = b[i];
    end
    for (int k = 0; k < A; k++) begin
      for (int i = 0; i < N; i++) begin
        int p = ((i << 1) | (i >> (A - 1))) & (N - 1);
        sv[p] = cv[i]; sd[p] = cd[i]; ss[p] = cs[i]; sx[p] = cx[i]; sb[p] = cb[i];
      end
      for (int i = 0; i < N; i++) begin cv[i] = 0; cb[i] = 0; end
      for (int j = 0; j < N / 2; j++) begin
        int u = 2 * j;
        int l = 2 * j + 1;
        bit ua = sv[u];
        bit la = sv[l];
        int ubit = (sd[u] >> (A - 1 - k)) & 1;
        int lbit = (sd[l] >> (A - 1 - k)) & 1;
        if (k == 0 && sv[u] && sb[u]) begin
          if (sv[l]) eb[ss[u]] = 1'b1;
          else for (int o = u; o <= l; o++) begin
            cv[o] = 1; cd[o] = sd[u]; cs[o] = ss[u]; cx[o] = sx[u];
          end
          ua = 0;
        end
        if (k == 0 && sv[l] && sb[l]) begin
          if (sv[u]) eb[ss[l]] = 1'b1;
          else for (int o = u; o <= l; o++) begin
            cv[o] = 1; cd[o] = sd[l]; cs[o] = ss[l]; cx[o] = sx[l];
          end
          la = 0;
        end
        if (ua && la && ubit == lbit) begin eb[ss[l]] = 1'b1; la = 0; end
        if (ua) begin cv[u+ubit] = 1; cd[u+ubit] = sd[u]; cs[u+ubit] = ss[u]; cx[u+ubit] = sx[u]; end
        if (la) begin cv[u+lbit] = 1; cd[u+lbit] = sd[l]; cs[u+lbit] = ss[l]; cx[u+lbit] = sx[l]; end
      end
    end
    for (int p = 0; p < N; p++) begin
      ev[p] = cv[p];
      ex[p] = cv[p] ? cx[p] : '0;
    end
  endtask

  task automatic load(int w, logic [N-1:0] v, logic [N-1:0] b, logic [N-1:0][A-1:0] d,
                      logic [N-1:0][DW-1:0] x, string tv, string tb);
    in_valid = v; in_bcast = b; in_dest = d; in_data = x;
    model(v, b, d, x, q_ev[w], q_eb[w], q_ex[w]);
    q_tv[w] = tv; q_tb[w] = tb;
  endtask

  task automatic idle();
    in_valid = '0; in_bcast = '0; in_dest = '0; in_data = '0;
  endtask

  task automatic check_wave(int w);
    logic [N-1:0][DW-1:0] md;
    for (int p = 0; p < N; p++) md[p] = q_ev[w][p] ? out_data[p] : '0;
    check(q_tv[w], "valid", 64'(out_valid), 64'(q_ev[w]));
    check(q_tv[w], "data", 64'(md), 64'(q_ex[w]));
    check(q_tb[w], "blocked", 64'(blocked), 64'(q_eb[w]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: got %0d cycles expected fewer", 20000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0][DW-1:0] x;
    // R7: outputs held at zero while reset is low, even with valid traffic
    @(negedge clk);
    in_valid = '1; in_bcast = 8'h0F; in_dest = 24'o76543210; in_data = '1;
    repeat (A + 1) @(negedge clk);
    check("R7", "valid in reset", 64'(out_valid), 64'h0);
    check("R7", "blocked in reset", 64'(blocked), 64'h0);
    idle();
    rst_ni = 1'b1;
    repeat (A + 1) @(negedge clk);
    check("R7", "valid after release", 64'(out_valid), 64'h0);
    check("R7", "blocked after release", 64'(blocked), 64'h0);

    // R1: single packet lane5 -> output 2, latency A
    in_valid = 8'h20; in_dest = 24'o00200000;
    in_data = '0; in_data[5] = 8'h5A;
    @(negedge clk);
    idle();
    for (int c = 1; c < A; c++) begin
      check("R1", "valid before latency", 64'(out_valid), 64'h0);
      @(negedge clk);
    end
    check("R1", "valid at latency", 64'(out_valid), 64'h04);
    check("R1", "data at latency", 64'(out_data[2]), 64'h5A);
    @(negedge clk);
    check("R1", "valid after wave", 64'(out_valid), 64'h0);

    // table walk, waves back to back
    for (int t = 0; t < 10 + A; t++) begin
      if (t >= A) check_wave(t - A);
      if (t < 10) begin
        for (int i = 0; i < N; i++) x[i] = VECS[t].seed + 8'(i * 29);
        load(t, VECS[t].v, VECS[t].b, VECS[t].d, x, tag(int'(VECS[t].req_v)), tag(int'(VECS[t].req_b)));
      end else idle();
      @(negedge clk);
    end

    // R8: pseudo-random waves, one per cycle, with sparse broadcast
    for (int t = 0; t < 60 + A; t++) begin
      if (t >= A) check_wave(t - A);
      if (t < 60) begin
        bit [31:0] r0 = rnd();
        bit [31:0] r1 = rnd();
        x = {rnd(), rnd()};
        load(t, r0[7:0], r0[15:8] & r0[23:16] & r0[31:24], r1[23:0], x, "R8", "R8");
      end else idle();
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule